// File: doc/BRIEF.md
# Direct-Mapped Mailbox FIFO Interface

This block links a host bus to an on-board controller. The host sees eight byte-wide register addresses and reaches each one directly, without a pointer register. The data port at address 0 feeds an outbound FIFO and drains an inbound FIFO. In word mode, the byte written earlier to address 1 becomes the upper half of the next entry. Address 2 reads a status byte and takes an interrupt mask on write. Address 3 holds two 6-bit mailboxes, one for each direction. A write to address 7 resets the block.

The board side drains the outbound FIFO and reads the outbound mailbox. It also fills the inbound FIFO and the inbound mailbox, and it turns on the host interrupt. A word-mode input sets the FIFO capacity. In byte mode only half of the entries are usable.

Top module: `mbx_fifo_bridge`

## Requirements
- R1: After reset, the status byte reads 0x21 (both FIFOs empty, no mailbox flags), `host_irq` is 0 and the address-3 read returns 0.
- R2: In byte mode (`host_word_mode`=0), each host write to address 0 adds one outbound entry {8'h00, byte}. The board reads the entries in write order, and `brd_out_data` is 0 when the FIFO is empty.
- R3: In word mode, a write to address 0 adds one entry {last byte written to address 1, byte written to address 0}.
- R4: The FIFO capacity is DEPTH entries in word mode and DEPTH/2 in byte mode. Full is set at capacity, and half-full is set at half of capacity or more. A push into a full FIFO is dropped.
- R5: A host read of address 0 returns the inbound head entry and removes it. A read of an empty inbound FIFO returns 0 and changes nothing.
- R6: The status bits are: 7 outbound mailbox unread, 6 outbound full, 5 inbound empty, 4 outbound half, 3 inbound half, 2 inbound mailbox full, 1 inbound full, 0 outbound empty.
- R7: Both mailboxes store only bits 7..2, and bits 1..0 always read 0.
- R8: A host write to address 3 loads the outbound mailbox and sets status bit 7. A board read (`brd_mbx_out_rd`) clears bit 7 but keeps the stored value.
- R9: While mask bit 7 is set, an address-3 read returns the outbound mailbox and leaves status bit 2 unchanged. While mask bit 7 is clear, the read returns the inbound mailbox.
- R10: A board mailbox write sets status bit 2. A host address-3 read while mask bit 7 is clear clears bit 2.
- R11: `host_irq` is the OR of the enabled conditions, gated by an enable that reset clears and `brd_irq_en_set` sets. The mask bits map to conditions as follows: 6 inbound mailbox full, 5 inbound full, 3 inbound empty, 2 outbound full, 0 outbound empty. Mask bit 7 raises no interrupt.
- R12: A write to address 7 restores the R1 state, which also clears the FIFOs, the mask and the interrupt enable. A read of address 7 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_word_mode | input | 1 | 1 selects 16-bit data entries |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 16 | Read data for the current address |
| host_irq | output | 1 | Host interrupt |
| brd_out_pop | input | 1 | Board takes the outbound head entry |
| brd_out_data | output | 16 | Outbound head entry |
| brd_out_valid | output | 1 | Outbound FIFO not empty |
| brd_in_push | input | 1 | Board adds an inbound entry |
| brd_in_data | input | 16 | Inbound entry |
| brd_in_full | output | 1 | Inbound FIFO full |
| brd_mbx_in_wr | input | 1 | Board loads the inbound mailbox |
| brd_mbx_in_data | input | 6 | Inbound mailbox bits 7..2 |
| brd_mbx_in_full | output | 1 | Inbound mailbox not yet read by host |
| brd_mbx_out_rd | input | 1 | Board consumes the outbound mailbox |
| brd_mbx_out_data | output | 8 | Outbound mailbox value |
| brd_mbx_out_full | output | 1 | Outbound mailbox unread |
| brd_irq_en_set | input | 1 | Turns on the host interrupt |

## Verification
Read data, status and `host_irq` are combinational from the registered state. A strobe therefore shows its effect in those outputs on the cycle after the clock edge that samples it. A read returns the pre-pop value during the strobe cycle itself. The bench drives each strobe on a falling edge and holds it through one rising edge. It samples read data 1 ns after driving, before that rising edge. It samples every other result on a later falling edge, half a period after the state has changed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int HB = 8;   // host byte width
    localparam int MB = 6;   // stored mailbox bits (7..2)

    typedef struct packed {
        logic [HB-1:0] mask;
        logic [HB-1:0] hi;
        logic [MB-1:0] mb_in;
        logic          mb_in_full;
        logic [MB-1:0] mb_out;
        logic          mb_out_busy;
        logic          gen;
    } ctl_t;

    typedef struct packed {
        logic out_full;
        logic out_half;
        logic out_empty;
        logic in_full;
        logic in_half;
        logic in_empty;
        logic mb_in_full;
        logic mb_out_busy;
    } flags_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          half_cap,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic          half
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;
    localparam logic [CW-1:0] CAP_W = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_B = CW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t s_d, s_q;
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cap;
    logic push_ok, pop_ok;

    assign cap     = half_cap ? CAP_B : CAP_W;
    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt >= cap);
    assign half    = (s_q.cnt >= (cap >> 1));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = empty ? '0 : mem[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (push_ok) s_d.wp = s_q.wp + 1'b1;
        if (pop_ok)  s_d.rp = s_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[s_q.wp] <= din;
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CAP_W); // R4
    AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> $stable(s_q.cnt)); // R4
    AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty); // R5
endmodule

// File: rtl/mbx_stat.sv
module mbx_stat
    import mbx_pkg::*;
(
    input  flags_t      fl,
    input  logic [4:0]  irq_en,   // {in mbx, in full, in empty, out full, out empty}
    input  logic        gen,
    output logic [7:0]  status,
    output logic        irq
);
    logic [4:0] cond;

    always_comb begin
        status = {fl.mb_out_busy, fl.out_full, fl.in_empty, fl.out_half,
                  fl.in_half, fl.mb_in_full, fl.in_full, fl.out_empty};
        cond   = {fl.mb_in_full, fl.in_full, fl.in_empty, fl.out_full, fl.out_empty};
        irq    = gen && |(cond & irq_en);
    end
endmodule

// File: rtl/mbx_fifo_bridge.sv
module mbx_fifo_bridge
    import mbx_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_word_mode,
    input  logic [2:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_irq,
    input  logic          brd_out_pop,
    output logic [DW-1:0] brd_out_data,
    output logic          brd_out_valid,
    input  logic          brd_in_push,
    input  logic [DW-1:0] brd_in_data,
    output logic          brd_in_full,
    input  logic          brd_mbx_in_wr,
    input  logic [5:0]    brd_mbx_in_data,
    output logic          brd_mbx_in_full,
    input  logic          brd_mbx_out_rd,
    output logic [7:0]    brd_mbx_out_data,
    output logic          brd_mbx_out_full,
    input  logic          brd_irq_en_set
);
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_HI   = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_MBX  = 3'd3;
    localparam logic [2:0] A_RST  = 3'd7;

    ctl_t c_d, c_q;
    flags_t fl;
    logic [7:0] status;
    logic [DW-1:0] out_din, in_dout;
    logic out_empty, out_full, out_half, in_empty, in_full, in_half;
    logic srst, wr_data, rd_data, wr_mbx, rd_mbx;
    logic unused_mask;

    assign srst    = host_wr && (host_addr == A_RST);
    assign wr_data = host_wr && (host_addr == A_DATA);
    assign rd_data = host_rd && (host_addr == A_DATA);
    assign wr_mbx  = host_wr && (host_addr == A_MBX);
    assign rd_mbx  = host_rd && (host_addr == A_MBX);
    assign unused_mask = c_q.mask[4] ^ c_q.mask[1];

    assign out_din = host_word_mode ? DW'({c_q.hi, host_wdata}) : DW'(host_wdata);

    mbx_fifo #(.DW(DW), .AW(AW)) u_out_fifo (
        .clk(clk), .rst_n(rst_n), .clr(srst), .half_cap(!host_word_mode),
        .push(wr_data), .din(out_din), .pop(brd_out_pop),
        .dout(brd_out_data), .empty(out_empty), .full(out_full), .half(out_half)
    );

    mbx_fifo #(.DW(DW), .AW(AW)) u_in_fifo (
        .clk(clk), .rst_n(rst_n), .clr(srst), .half_cap(!host_word_mode),
        .push(brd_in_push), .din(brd_in_data), .pop(rd_data),
        .dout(in_dout), .empty(in_empty), .full(in_full), .half(in_half)
    );

    always_comb begin
        fl.out_full    = out_full;
        fl.out_half    = out_half;
        fl.out_empty   = out_empty;
        fl.in_full     = in_full;
        fl.in_half     = in_half;
        fl.in_empty    = in_empty;
        fl.mb_in_full  = c_q.mb_in_full;
        fl.mb_out_busy = c_q.mb_out_busy;
    end

    mbx_stat u_stat (
        .fl(fl),
        .irq_en({c_q.mask[6], c_q.mask[5], c_q.mask[3], c_q.mask[2], c_q.mask[0]}),
        .gen(c_q.gen),
        .status(status),
        .irq(host_irq)
    );

    always_comb begin
        c_d = c_q;
        if (host_wr && host_addr == A_HI)   c_d.hi   = host_wdata;
        if (host_wr && host_addr == A_STAT) c_d.mask = host_wdata;
        if (brd_mbx_out_rd) c_d.mb_out_busy = 1'b0;
        if (wr_mbx) begin
            c_d.mb_out      = host_wdata[7:2];
            c_d.mb_out_busy = 1'b1;
        end
        if (rd_mbx && !c_q.mask[7]) c_d.mb_in_full = 1'b0;
        if (brd_mbx_in_wr) begin
            c_d.mb_in      = brd_mbx_in_data;
            c_d.mb_in_full = 1'b1;
        end
        if (brd_irq_en_set) c_d.gen = 1'b1;
        if (srst) c_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        case (host_addr)
            A_DATA:  host_rdata = in_dout;
            A_STAT:  host_rdata = DW'(status);
            A_MBX:   host_rdata = DW'({(c_q.mask[7] ? c_q.mb_out : c_q.mb_in), 2'b00});
            default: host_rdata = '0;
        endcase
    end

    assign brd_out_valid    = !out_empty;
    assign brd_in_full      = in_full;
    assign brd_mbx_in_full  = c_q.mb_in_full;
    assign brd_mbx_out_data = {c_q.mb_out, 2'b00};
    assign brd_mbx_out_full = c_q.mb_out_busy;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.gen |-> !host_irq); // R11
    AST_MBOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mbx && !srst) |=> status[7]); // R8
    AST_MBOUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_mbx_out_rd && !wr_mbx && !srst) |=> ($stable(brd_mbx_out_data) && !brd_mbx_out_full)); // R8
    AST_INMB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mbx && !c_q.mask[7] && !brd_mbx_in_wr && !srst) |=> !status[2]); // R10
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!host_irq && !brd_out_valid && status[7:6] == 2'b00)); // R12
endmodule

// File: tb/mbx_fifo_bridge_tb_top.sv
module mbx_fifo_bridge_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_word_mode = 1'b0;
    logic [2:0] host_addr = '0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic host_irq;
    logic brd_out_pop = 1'b0;
    logic [15:0] brd_out_data;
    logic brd_out_valid;
    logic brd_in_push = 1'b0;
    logic [15:0] brd_in_data = '0;
    logic brd_in_full;
    logic brd_mbx_in_wr = 1'b0;
    logic [5:0] brd_mbx_in_data = '0;
    logic brd_mbx_in_full;
    logic brd_mbx_out_rd = 1'b0;
    logic [7:0] brd_mbx_out_data;
    logic brd_mbx_out_full;
    logic brd_irq_en_set = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // {mask byte, expected irq} with both FIFOs empty and no mailbox flags
    localparam logic [8:0] IRQ_TAB [8] = '{
        {8'h01, 1'b1}, {8'h08, 1'b1}, {8'h04, 1'b0}, {8'h20, 1'b0},
        {8'h40, 1'b0}, {8'h80, 1'b0}, {8'h00, 1'b0}, {8'h09, 1'b1}
    };

    always #2 clk = ~clk;

    mbx_fifo_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_word_mode(host_word_mode),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .brd_out_pop(brd_out_pop), .brd_out_data(brd_out_data), .brd_out_valid(brd_out_valid),
        .brd_in_push(brd_in_push), .brd_in_data(brd_in_data), .brd_in_full(brd_in_full),
        .brd_mbx_in_wr(brd_mbx_in_wr), .brd_mbx_in_data(brd_mbx_in_data),
        .brd_mbx_in_full(brd_mbx_in_full), .brd_mbx_out_rd(brd_mbx_out_rd),
        .brd_mbx_out_data(brd_mbx_out_data), .brd_mbx_out_full(brd_mbx_out_full),
        .brd_irq_en_set(brd_irq_en_set)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic status_rd(output logic [15:0] v);
        hrd(3'd2, v);
    endtask

    task automatic bpop(output logic [15:0] v);
        @(negedge clk);
        v = brd_out_data; brd_out_pop = 1'b1;
        @(negedge clk);
        brd_out_pop = 1'b0;
    endtask

    task automatic bpush(input logic [15:0] d);
        @(negedge clk);
        brd_in_data = d; brd_in_push = 1'b1;
        @(negedge clk);
        brd_in_push = 1'b0;
    endtask

    task automatic bmbx(input logic [5:0] d);
        @(negedge clk);
        brd_mbx_in_data = d; brd_mbx_in_wr = 1'b1;
        @(negedge clk);
        brd_mbx_in_wr = 1'b0;
    endtask

    task automatic bmbx_rd();
        @(negedge clk);
        brd_mbx_out_rd = 1'b1;
        @(negedge clk);
        brd_mbx_out_rd = 1'b0;
    endtask

    task automatic ben();
        @(negedge clk);
        brd_irq_en_set = 1'b1;
        @(negedge clk);
        brd_irq_en_set = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        status_rd(v); check("R1 status after reset", v, 16'h0021);
        check("R1 irq after reset", {15'd0, host_irq}, 16'h0000);
        hrd(3'd3, v); check("R1 mailbox after reset", v, 16'h0000);

        // R2 byte mode order
        hwr(3'd0, 8'h5A); hwr(3'd0, 8'hC3);
        status_rd(v); check("R6 status two outbound bytes", v, 16'h0030);
        bpop(v); check("R2 first byte", v, 16'h005A);
        bpop(v); check("R2 second byte", v, 16'h00C3);
        check("R2 empty data zero", brd_out_data, 16'h0000);
        check("R2 valid low when empty", {15'd0, brd_out_valid}, 16'h0000);

        // R4 byte-mode capacity is DEPTH/2 = 4
        for (int i = 1; i <= 5; i++) hwr(3'd0, 8'(i));
        status_rd(v); check("R4 byte mode full", v, 16'h0070);
        for (int i = 1; i <= 4; i++) begin
            bpop(v); check("R4 byte mode drain", v, 16'(i));
        end
        check("R4 fifth byte dropped", {15'd0, brd_out_valid}, 16'h0000);

        // R3 word mode, R4 capacity DEPTH = 8
        host_word_mode = 1'b1;
        hwr(3'd1, 8'hAB); hwr(3'd0, 8'hCD);
        for (int i = 1; i <= 3; i++) begin hwr(3'd1, 8'(8'h10 + i)); hwr(3'd0, 8'(8'h20 + i)); end
        status_rd(v); check("R4 word mode half not full", v, 16'h0030);
        for (int i = 4; i <= 7; i++) begin hwr(3'd1, 8'(8'h10 + i)); hwr(3'd0, 8'(8'h20 + i)); end
        status_rd(v); check("R4 word mode full", v, 16'h0070);
        hwr(3'd1, 8'hEE); hwr(3'd0, 8'hEE);
        bpop(v); check("R3 word entry", v, 16'hABCD);
        for (int i = 1; i <= 7; i++) begin
            bpop(v); check("R3 word drain", v, {8'(8'h10 + i), 8'(8'h20 + i)});
        end
        check("R4 ninth word dropped", {15'd0, brd_out_valid}, 16'h0000);

        // R5 inbound path
        bpush(16'h1234); bpush(16'h5678);
        status_rd(v); check("R6 inbound not empty", v, 16'h0001);
        hrd(3'd0, v); check("R5 inbound head", v, 16'h1234);
        hrd(3'd0, v); check("R5 inbound second", v, 16'h5678);
        hrd(3'd0, v); check("R5 empty read zero", v, 16'h0000);
        status_rd(v); check("R5 inbound empty again", v, 16'h0021);
        for (int i = 0; i < 9; i++) bpush(16'h1000 + 16'(i));
        status_rd(v); check("R4 inbound full flags", v, 16'h000B);
        check("R4 board sees in full", {15'd0, brd_in_full}, 16'h0001);
        for (int i = 0; i < 8; i++) begin
            hrd(3'd0, v); check("R5 inbound drain", v, 16'h1000 + 16'(i));
        end
        status_rd(v); check("R5 inbound drained", v, 16'h0021);

        // R7 R8 R9 R10 mailboxes
        bmbx(6'h3F);
        status_rd(v); check("R10 inbound mailbox flag", v, 16'h0025);
        hrd(3'd3, v); check("R7 inbound mailbox low bits", v, 16'h00FC);
        status_rd(v); check("R10 flag cleared by read", v, 16'h0021);
        hwr(3'd3, 8'h77);
        status_rd(v); check("R8 outbound unread flag", v, 16'h00A1);
        check("R7 board view of outbound", brd_mbx_out_data, 16'h0074);
        bmbx_rd();
        status_rd(v); check("R8 flag cleared by board", v, 16'h0021);
        check("R8 value kept", brd_mbx_out_data, 16'h0074);
        hwr(3'd2, 8'h80);
        hrd(3'd3, v); check("R9 readback outbound", v, 16'h0074);
        bmbx(6'h02);
        hrd(3'd3, v); check("R9 select still outbound", v, 16'h0074);
        status_rd(v); check("R9 inbound flag kept", v, 16'h0025);
        hwr(3'd2, 8'h00);
        hrd(3'd3, v); check("R9 inbound selected", v, 16'h0008);
        status_rd(v); check("R10 flag cleared", v, 16'h0021);

        // R11 interrupt gating and mapping
        hwr(3'd2, 8'h01);
        check("R11 irq gated before enable", {15'd0, host_irq}, 16'h0000);
        ben();
        for (int i = 0; i < 8; i++) begin
            hwr(3'd2, IRQ_TAB[i][8:1]);
            check("R11 irq table", {15'd0, host_irq}, {15'd0, IRQ_TAB[i][0]});
        end
        bmbx(6'h01); hwr(3'd2, 8'h40);
        check("R11 irq on inbound mailbox", {15'd0, host_irq}, 16'h0001);
        hrd(3'd3, v);
        check("R11 irq drops after read", {15'd0, host_irq}, 16'h0000);
        hwr(3'd2, 8'h04);
        for (int i = 0; i < 8; i++) hwr(3'd0, 8'(i));
        check("R11 irq on outbound full", {15'd0, host_irq}, 16'h0001);

        // R12 soft reset and read of 7
        hwr(3'd7, 8'h00);
        status_rd(v); check("R12 status after soft reset", v, 16'h0021);
        check("R12 outbound cleared", {15'd0, brd_out_valid}, 16'h0000);
        hwr(3'd2, 8'h01);
        check("R12 enable cleared", {15'd0, host_irq}, 16'h0000);
        hwr(3'd0, 8'h42);
        hrd(3'd7, v); check("R12 read of 7 zero", v, 16'h0000);
        status_rd(v); check("R12 read of 7 no effect", v, 16'h0020);
        check("R12 data kept", brd_out_data, 16'h0042);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule